// File: doc/BRIEF.md
# Cartridge Bank and Nametable Mapper

This block sits between a console's CPU and picture-processor buses and the memories of a game cartridge. CPU writes into the upper half of the address space land in a set of bank registers instead of memory. From those registers the block turns each CPU address into a program-ROM or work-RAM address, and each picture-processor address into either a character-memory address or an address in the console's own 2 KB video RAM.

Twelve 1 KB bank registers cover the picture side: eight for the pattern-table slots at 0x0000–0x1FFF and four for the nametable quadrants at 0x2000–0x2FFF (mirrored up to 0x3FFF). A bank value of 0xE0 or more sends the access to video RAM, page chosen by the value's bit 0. On the CPU side, three 8 KB program windows can be selected and a fourth is fixed to the last bank. The block also exports a two-bit mirroring mode and an audio-mute flag, and it gates work-RAM writes through a protect register that must hold a specific prefix before any write is let through. Decode is combinational. Register writes are captured on the clock edge that ends the write strobe.

Top module: `cart_bank_mapper`

## Requirements
- R1: After synchronous reset every register is zero: slot 0 maps character bank 0, CPU 0x8000 maps program bank 0, `audio_off` and `mirror_mode` are 0 and no work-RAM write is enabled.
- R2: A CPU write to 0x8000–0xDFFF loads bank register n = cpu_addr[14:11]. Registers 0–7 give the 1 KB bank of pattern slot ppu_addr[12:10], so `chr_addr` = {bank, ppu_addr[9:0]}.
- R3: Registers 8–11 give the bank of nametable quadrant ppu_addr[11:10] for ppu_addr[13]=1. Below 0xE0 the access goes to character memory (`chr_sel`=1).
- R4: A bank value of 0xE0 or more drives `vram_sel`=1, `chr_sel`=0 and `vram_addr` = {value[0], ppu_addr[9:0]}. For nametable quadrants this redirect always applies.
- R5: For pattern slots, bit 6 of the value written in window 0xE800–0xEFFF cancels the redirect for slots 0–3, and bit 7 cancels it for slots 4–7. A cancelled slot reads character memory.
- R6: Bank values that stay in character memory are reduced modulo CHR_BANKS (default 128, so 0xC5 maps to 0x45).
- R7: Writes to windows 0xE000, 0xE800 and 0xF000 set the 8 KB program bank for 0x8000, 0xA000 and 0xC000 from the value's low 6 bits. 0xE000–0xFFFF always maps bank PRG_BANKS−1, and `prg_rom_addr` = {bank, cpu_addr[12:0]}.
- R8: `audio_off` takes bit 6 of each write in window 0xE000–0xE7FF. Writes elsewhere leave it unchanged.
- R9: A write to bank register 11 (0xD800–0xDFFF) sets `mirror_mode` to the value's bits 1:0 (0 vertical, 1 horizontal, 2 single-screen lower, 3 single-screen upper).
- R10: `wram_we` is 1 only for a CPU write to 0x6000–0x7FFF while the value last written at 0xF800–0xFFFF lies in 0x40–0x4E and bit cpu_addr[12:11] of that value is 0.
- R11: A register write takes effect from the cycle after the strobe. During the strobe cycle the outputs still reflect the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 14 | Picture-processor address |
| prg_rom_addr | output | PRG_AW | Program-ROM byte address |
| prg_rom_sel | output | 1 | CPU read in 0x8000–0xFFFF |
| wram_addr | output | 13 | Work-RAM byte address |
| wram_sel | output | 1 | CPU access in 0x6000–0x7FFF |
| wram_we | output | 1 | Work-RAM write enable after protection |
| chr_addr | output | CHR_AW | Character-memory byte address |
| chr_sel | output | 1 | Picture access goes to character memory |
| vram_addr | output | 11 | Console video-RAM address |
| vram_sel | output | 1 | Picture access goes to video RAM |
| mirror_mode | output | 2 | Nametable arrangement mode |
| audio_off | output | 1 | Latched audio-mute flag |

## Verification
The checker assumes that `cpu_wr` is a single-cycle strobe with `cpu_addr` and `cpu_wdata` stable across the sampling edge. It also assumes that `ppu_addr` does not move within a cycle in which the selects are compared. The bench drives every input on the falling clock edge and holds each write for exactly one rising edge, so each register captures one value. The exclusive-select and offset properties rest on the decode being purely combinational. The bench samples those outputs only after the inputs settle.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

   localparam int          NUM_BANK_REGS = 12;
   localparam int          PATTERN_SLOTS = 8;
   localparam logic [7:0]  VRAM_BANK_MIN = 8'hE0;
   localparam logic [7:0]  PROT_KEY_LO   = 8'h40;
   localparam logic [7:0]  PROT_KEY_HI   = 8'h4E;
   localparam int          PRG_SEL_W     = 6;

   typedef enum logic [1:0] {
      MIR_VERT  = 2'd0,
      MIR_HORIZ = 2'd1,
      MIR_LOW   = 2'd2,
      MIR_HIGH  = 2'd3
   } mirror_e;

   typedef enum logic [4:0] {
      WIN_PRG0 = 5'h1C,
      WIN_PRG1 = 5'h1D,
      WIN_PRG2 = 5'h1E,
      WIN_PROT = 5'h1F
   } upper_win_e;

endpackage

// File: rtl/cbm_regs.sv
module cbm_regs
   import cbm_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr,
   input  logic [15:11]         addr_hi,
   input  logic [7:0]           wdata,
   output logic [7:0]           bank_q    [NUM_BANK_REGS],
   output logic [PRG_SEL_W-1:0] prg_sel_q [3],
   output logic [1:0]           ctrl_q,
   output logic [7:0]           protect_q,
   output logic                 audio_off_q
);

   logic [4:0] prg_win [3];
   assign prg_win[0] = WIN_PRG0;
   assign prg_win[1] = WIN_PRG1;
   assign prg_win[2] = WIN_PRG2;

   // bank registers 0..11 occupy 0x8000-0xDFFF, 2 KB apart
   for (genvar g = 0; g < NUM_BANK_REGS; g++) begin : g_bank
      logic hit;
      assign hit = wr && addr_hi[15] && (addr_hi[14:11] == 4'(g));
      always_ff @(posedge clk) begin
         if (rst)      bank_q[g] <= '0;
         else if (hit) bank_q[g] <= wdata;
      end
   end

   for (genvar p = 0; p < 3; p++) begin : g_prg
      always_ff @(posedge clk) begin
         if (rst)                                  prg_sel_q[p] <= '0;
         else if (wr && (addr_hi == prg_win[p]))   prg_sel_q[p] <= wdata[PRG_SEL_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q      <= '0;
         protect_q   <= '0;
         audio_off_q <= 1'b0;
      end else if (wr) begin
         if (addr_hi == WIN_PRG1) ctrl_q      <= wdata[7:6];
         if (addr_hi == WIN_PROT) protect_q   <= wdata;
         if (addr_hi == WIN_PRG0) audio_off_q <= wdata[6];
      end
   end

endmodule

// File: rtl/cbm_cpu_decode.sv
module cbm_cpu_decode
   import cbm_pkg::*;
#(
   parameter  int PRG_BANKS = 64,
   localparam int PRG_BW    = $clog2(PRG_BANKS),
   localparam int PRG_AW    = PRG_BW + 13
)(
   input  logic [15:0]          cpu_addr,
   input  logic                 cpu_wr,
   input  logic [PRG_SEL_W-1:0] prg_sel_q [3],
   input  logic [7:0]           protect_q,
   output logic [PRG_AW-1:0]    prg_rom_addr,
   output logic                 prg_rom_sel,
   output logic [12:0]          wram_addr,
   output logic                 wram_sel,
   output logic                 wram_we
);

   localparam logic [PRG_BW-1:0] LAST_BANK = PRG_BW'(PRG_BANKS - 1);

   logic [1:0]        slot;
   logic [PRG_BW-1:0] bank;
   logic              key_ok;
   logic              win_blocked;

   assign slot = cpu_addr[14:13];

   always_comb begin
      if (slot == 2'd3) bank = LAST_BANK;
      else              bank = prg_sel_q[slot][PRG_BW-1:0];
   end

   assign prg_rom_addr = {bank, cpu_addr[12:0]};
   assign prg_rom_sel  = cpu_addr[15] && !cpu_wr;

   assign key_ok      = (protect_q >= PROT_KEY_LO) && (protect_q <= PROT_KEY_HI);
   assign win_blocked = protect_q[cpu_addr[12:11]];

   assign wram_addr = cpu_addr[12:0];
   assign wram_sel  = (cpu_addr[15:13] == 3'b011);
   assign wram_we   = wram_sel && cpu_wr && key_ok && !win_blocked;

endmodule

// File: rtl/cbm_ppu_decode.sv
module cbm_ppu_decode
   import cbm_pkg::*;
#(
   parameter  int CHR_BANKS = 128,
   localparam int CHR_BW    = $clog2(CHR_BANKS),
   localparam int CHR_AW    = CHR_BW + 10
)(
   input  logic [13:0]       ppu_addr,
   input  logic [7:0]        bank_q [NUM_BANK_REGS],
   input  logic [1:0]        ctrl_q,
   output logic [CHR_AW-1:0] chr_addr,
   output logic              chr_sel,
   output logic [10:0]       vram_addr,
   output logic              vram_sel
);

   logic [3:0]        reg_idx;
   logic [7:0]        bank;
   logic              is_nt;
   logic              cancel;
   logic              redirect;
   logic [CHR_BW-1:0] red_bank;

   assign is_nt   = ppu_addr[13];
   assign reg_idx = is_nt ? {2'b10, ppu_addr[11:10]} : {1'b0, ppu_addr[12:10]};
   assign bank    = bank_q[reg_idx];

   // bit 6 guards the low pattern half, bit 7 the high half
   assign cancel   = !is_nt && (ppu_addr[12] ? ctrl_q[1] : ctrl_q[0]);
   assign redirect = (bank >= VRAM_BANK_MIN) && !cancel;

   if ((1 << CHR_BW) == CHR_BANKS) begin : g_pow2
      assign red_bank = bank[CHR_BW-1:0];
   end else begin : g_modulo
      logic [8:0] rem;
      assign rem      = {1'b0, bank} % 9'(CHR_BANKS);
      assign red_bank = rem[CHR_BW-1:0];
   end

   assign chr_addr  = {red_bank, ppu_addr[9:0]};
   assign chr_sel   = !redirect;
   assign vram_addr = {bank[0], ppu_addr[9:0]};
   assign vram_sel  = redirect;

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
   import cbm_pkg::*;
#(
   parameter  int PRG_BANKS = 64,
   parameter  int CHR_BANKS = 128,
   localparam int PRG_AW    = $clog2(PRG_BANKS) + 13,
   localparam int CHR_AW    = $clog2(CHR_BANKS) + 10
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_wdata,
   input  logic              cpu_wr,
   input  logic [13:0]       ppu_addr,
   output logic [PRG_AW-1:0] prg_rom_addr,
   output logic              prg_rom_sel,
   output logic [12:0]       wram_addr,
   output logic              wram_sel,
   output logic              wram_we,
   output logic [CHR_AW-1:0] chr_addr,
   output logic              chr_sel,
   output logic [10:0]       vram_addr,
   output logic              vram_sel,
   output logic [1:0]        mirror_mode,
   output logic              audio_off
);

   initial begin
      assert (PRG_BANKS >= 2 && PRG_BANKS <= 64 && (1 << $clog2(PRG_BANKS)) == PRG_BANKS)
         else $error("PRG_BANKS must be a power of two in 2..64");
      assert (CHR_BANKS >= 2 && CHR_BANKS <= 256)
         else $error("CHR_BANKS must lie in 2..256");
   end

   logic [7:0]           bank_q    [NUM_BANK_REGS];
   logic [PRG_SEL_W-1:0] prg_sel_q [3];
   logic [1:0]           ctrl_q;
   logic [7:0]           protect_q;
   mirror_e              mirror;

   cbm_regs u_regs (
      .clk         (clk),
      .rst         (rst),
      .wr          (cpu_wr),
      .addr_hi     (cpu_addr[15:11]),
      .wdata       (cpu_wdata),
      .bank_q      (bank_q),
      .prg_sel_q   (prg_sel_q),
      .ctrl_q      (ctrl_q),
      .protect_q   (protect_q),
      .audio_off_q (audio_off)
   );

   cbm_cpu_decode #(.PRG_BANKS(PRG_BANKS)) u_cpu (
      .cpu_addr     (cpu_addr),
      .cpu_wr       (cpu_wr),
      .prg_sel_q    (prg_sel_q),
      .protect_q    (protect_q),
      .prg_rom_addr (prg_rom_addr),
      .prg_rom_sel  (prg_rom_sel),
      .wram_addr    (wram_addr),
      .wram_sel     (wram_sel),
      .wram_we      (wram_we)
   );

   cbm_ppu_decode #(.CHR_BANKS(CHR_BANKS)) u_ppu (
      .ppu_addr  (ppu_addr),
      .bank_q    (bank_q),
      .ctrl_q    (ctrl_q),
      .chr_addr  (chr_addr),
      .chr_sel   (chr_sel),
      .vram_addr (vram_addr),
      .vram_sel  (vram_sel)
   );

   // the mode lives in the low bits of the last nametable register
   assign mirror      = mirror_e'(bank_q[NUM_BANK_REGS-1][1:0]);
   assign mirror_mode = mirror;

endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
   parameter int PRG_BANKS = 64,
   localparam int PRG_BW   = $clog2(PRG_BANKS)
)(
   input logic              clk,
   input logic              rst,
   input logic [15:11]      addr_hi,
   input logic              cpu_wr,
   input logic              wdata_b6,
   input logic [1:0]        wdata_lo,
   input logic [9:0]        ppu_off,
   input logic [PRG_BW-1:0] prg_bank,
   input logic              wram_we,
   input logic [9:0]        chr_off,
   input logic              chr_sel,
   input logic [9:0]        vram_off,
   input logic              vram_sel,
   input logic [1:0]        mirror_mode,
   input logic              audio_off
);

   logic aud_wr, mir_wr;
   assign aud_wr = cpu_wr && (addr_hi == 5'h1C);
   assign mir_wr = cpu_wr && (addr_hi == 5'h1B);

   assert_one_target_R4: assert property (@(posedge clk) disable iff (rst)
      $countones({chr_sel, vram_sel}) == 1);

   assert_vram_offset_R4: assert property (@(posedge clk) disable iff (rst)
      vram_sel |-> (vram_off == ppu_off));

   assert_chr_offset_R2: assert property (@(posedge clk) disable iff (rst)
      chr_sel |-> (chr_off == ppu_off));

   assert_last_bank_R7: assert property (@(posedge clk) disable iff (rst)
      (addr_hi[15:13] == 3'b111) |-> (prg_bank == PRG_BW'(PRG_BANKS - 1)));

   assert_wram_gate_R10: assert property (@(posedge clk) disable iff (rst)
      wram_we |-> (cpu_wr && addr_hi[15:13] == 3'b011));

   assert_audio_load_R8: assert property (@(posedge clk) disable iff (rst)
      aud_wr |=> (audio_off == $past(wdata_b6)));

   assert_audio_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !aud_wr |=> $stable(audio_off));

   assert_mirror_load_R9: assert property (@(posedge clk) disable iff (rst)
      mir_wr |=> (mirror_mode == $past(wdata_lo)));

   assert_mirror_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !mir_wr |=> $stable(mirror_mode));

endmodule

bind cart_bank_mapper cbm_checker #(.PRG_BANKS(PRG_BANKS)) u_cbm_checker (
   .clk         (clk),
   .rst         (rst),
   .addr_hi     (cpu_addr[15:11]),
   .cpu_wr      (cpu_wr),
   .wdata_b6    (cpu_wdata[6]),
   .wdata_lo    (cpu_wdata[1:0]),
   .ppu_off     (ppu_addr[9:0]),
   .prg_bank    (prg_rom_addr[PRG_AW-1:13]),
   .wram_we     (wram_we),
   .chr_off     (chr_addr[9:0]),
   .chr_sel     (chr_sel),
   .vram_off    (vram_addr[9:0]),
   .vram_sel    (vram_sel),
   .mirror_mode (mirror_mode),
   .audio_off   (audio_off)
);

// File: tb/test_cart_bank_mapper.sv
`timescale 1ns/1ps
module test_cart_bank_mapper;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_wr = 1'b0;
   logic [13:0] ppu_addr = '0;
   logic [18:0] prg_rom_addr;
   logic        prg_rom_sel;
   logic [12:0] wram_addr;
   logic        wram_sel;
   logic        wram_we;
   logic [16:0] chr_addr;
   logic        chr_sel;
   logic [10:0] vram_addr;
   logic        vram_sel;
   logic [1:0]  mirror_mode;
   logic        audio_off;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   cart_bank_mapper i_cart_bank_mapper (
      .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr),
      .prg_rom_sel(prg_rom_sel), .wram_addr(wram_addr), .wram_sel(wram_sel),
      .wram_we(wram_we), .chr_addr(chr_addr), .chr_sel(chr_sel),
      .vram_addr(vram_addr), .vram_sel(vram_sel), .mirror_mode(mirror_mode),
      .audio_off(audio_off)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0; cpu_addr = 16'h0000;
      #1;
   endtask

   task automatic ppu_probe(input logic [13:0] a);
      ppu_addr = a;
      #1;
   endtask

   task automatic cpu_probe(input logic [15:0] a);
      cpu_addr = a;
      #1;
   endtask

   // drive a work-RAM write strobe and sample its enable inside the strobe cycle
   task automatic wram_try(input logic [15:0] a, input logic exp, input string tag);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = 8'h5A; cpu_wr = 1'b1;
      #1;
      check(tag, {31'd0, wram_we}, {31'd0, exp});
      @(negedge clk);
      cpu_wr = 1'b0; cpu_addr = 16'h0000;
   endtask

   task automatic t_reset_state;
      ppu_probe(14'h0000);
      check("R1 chr_sel", {31'd0, chr_sel}, 32'd1);
      check("R1 chr_addr", {15'd0, chr_addr}, 32'd0);
      cpu_probe(16'h8000);
      check("R1 prg bank0", {13'd0, prg_rom_addr}, 32'd0);
      check("R1 audio_off", {31'd0, audio_off}, 32'd0);
      check("R1 mirror", {30'd0, mirror_mode}, 32'd0);
      wram_try(16'h6000, 1'b0, "R1 wram locked");
   endtask

   task automatic t_pattern_slots;
      for (int i = 0; i < 8; i++) cpu_write(16'h8000 + 16'(i) * 16'h0800, 8'(8'h10 + i));
      for (int i = 0; i < 8; i++) begin
         ppu_probe(14'(i * 14'h0400 + 14'h02A5));
         check("R2 pattern slot", {15'd0, chr_addr}, ((32'h10 + 32'(i)) << 10) | 32'h2A5);
         check("R2 pattern sel", {31'd0, chr_sel}, 32'd1);
      end
   endtask

   task automatic t_modulo;
      cpu_write(16'h9800, 8'hC5);
      ppu_probe(14'h0C07);
      check("R6 modulo C5", {15'd0, chr_addr}, (32'h45 << 10) | 32'h7);
      cpu_write(16'h9800, 8'hDF);
      ppu_probe(14'h0C07);
      check("R6 modulo DF", {15'd0, chr_addr}, (32'h5F << 10) | 32'h7);
   endtask

   task automatic t_nametables;
      cpu_write(16'hC000, 8'h07);
      cpu_write(16'hC800, 8'h0A);
      ppu_probe(14'h2013);
      check("R3 quadrant0", {15'd0, chr_addr}, (32'h07 << 10) | 32'h13);
      check("R3 quadrant0 sel", {31'd0, chr_sel}, 32'd1);
      ppu_probe(14'h3405);
      check("R3 quadrant1 mirror", {15'd0, chr_addr}, (32'h0A << 10) | 32'h5);
   endtask

   task automatic t_vram_redirect;
      cpu_write(16'hC000, 8'hE0);
      cpu_write(16'hC800, 8'hE1);
      cpu_write(16'hA800, 8'hE3);
      ppu_probe(14'h2100);
      check("R4 nt page0 sel", {31'd0, vram_sel}, 32'd1);
      check("R4 nt page0 chr_sel", {31'd0, chr_sel}, 32'd0);
      check("R4 nt page0 addr", {21'd0, vram_addr}, 32'h100);
      ppu_probe(14'h2500);
      check("R4 nt page1 addr", {21'd0, vram_addr}, 32'h500);
      ppu_probe(14'h1401);
      check("R4 pattern redirect", {31'd0, vram_sel}, 32'd1);
      check("R4 pattern addr", {21'd0, vram_addr}, 32'h401);
   endtask

   task automatic t_redirect_cancel;
      cpu_write(16'h8800, 8'hE2);
      cpu_write(16'hE800, 8'h40);
      ppu_probe(14'h0410);
      check("R5 low half cancelled", {31'd0, chr_sel}, 32'd1);
      check("R5 low half bank", {15'd0, chr_addr}, (32'h62 << 10) | 32'h10);
      ppu_probe(14'h1401);
      check("R5 high half kept", {31'd0, vram_sel}, 32'd1);
      cpu_write(16'hE800, 8'h80);
      ppu_probe(14'h0410);
      check("R5 low half restored", {21'd0, vram_addr}, 32'h010);
      check("R5 low half vram", {31'd0, vram_sel}, 32'd1);
      ppu_probe(14'h1401);
      check("R5 high half cancelled", {15'd0, chr_addr}, (32'h63 << 10) | 32'h1);
      ppu_probe(14'h2100);
      check("R5 nametable unaffected", {31'd0, vram_sel}, 32'd1);
      cpu_write(16'hE800, 8'h00);
   endtask

   task automatic t_prg_banks;
      cpu_write(16'hE000, 8'hC1);
      cpu_write(16'hE800, 8'h02);
      cpu_write(16'hF000, 8'h3F);
      cpu_probe(16'h8123);
      check("R7 window 8000", {13'd0, prg_rom_addr}, (32'd1 << 13) | 32'h123);
      check("R7 rom sel", {31'd0, prg_rom_sel}, 32'd1);
      cpu_probe(16'hA010);
      check("R7 window A000", {13'd0, prg_rom_addr}, (32'd2 << 13) | 32'h10);
      cpu_probe(16'hC000);
      check("R7 window C000", {13'd0, prg_rom_addr}, 32'd63 << 13);
      cpu_probe(16'hE456);
      check("R7 fixed last", {13'd0, prg_rom_addr}, (32'd63 << 13) | 32'h456);
      cpu_probe(16'h0000);
   endtask

   task automatic t_audio_flag;
      cpu_write(16'hE000, 8'h41);
      check("R8 audio set", {31'd0, audio_off}, 32'd1);
      cpu_write(16'hE800, 8'h00);
      check("R8 other window ignored", {31'd0, audio_off}, 32'd1);
      cpu_write(16'hE000, 8'h01);
      check("R8 audio clear", {31'd0, audio_off}, 32'd0);
   endtask

   task automatic t_mirror;
      for (int m = 0; m < 4; m++) begin
         cpu_write(16'hD800, 8'(m));
         check("R9 mirror mode", {30'd0, mirror_mode}, 32'(m));
      end
      cpu_write(16'hD000, 8'h01);
      check("R9 reg10 ignored", {30'd0, mirror_mode}, 32'd3);
      cpu_write(16'hD800, 8'h0E);
      check("R9 upper bits ignored", {30'd0, mirror_mode}, 32'd2);
   endtask

   task automatic t_wram_protect;
      cpu_write(16'hF800, 8'h40);
      wram_try(16'h6000, 1'b1, "R10 key 40 win0");
      wram_try(16'h7FFF, 1'b1, "R10 key 40 win3");
      cpu_write(16'hF800, 8'h41);
      wram_try(16'h6000, 1'b0, "R10 win0 blocked");
      wram_try(16'h6800, 1'b1, "R10 win1 open");
      cpu_write(16'hF800, 8'h4E);
      wram_try(16'h6000, 1'b1, "R10 4E win0 open");
      wram_try(16'h7000, 1'b0, "R10 4E win2 blocked");
      cpu_write(16'hF800, 8'h4F);
      wram_try(16'h6000, 1'b0, "R10 key 4F out of range");
      cpu_write(16'hF800, 8'h80);
      wram_try(16'h6800, 1'b0, "R10 key 80 out of range");
   endtask

   task automatic t_write_latency;
      cpu_write(16'h8000, 8'h11);
      ppu_probe(14'h0003);
      @(negedge clk);
      cpu_addr = 16'h8000; cpu_wdata = 8'h22; cpu_wr = 1'b1;
      #1;
      check("R11 old value in strobe", {15'd0, chr_addr}, (32'h11 << 10) | 32'h3);
      @(posedge clk);
      #1;
      check("R11 new value after edge", {15'd0, chr_addr}, (32'h22 << 10) | 32'h3);
      @(negedge clk);
      cpu_wr = 1'b0; cpu_addr = 16'h0000;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hang expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      t_reset_state();
      t_pattern_slots();
      t_modulo();
      t_nametables();
      t_vram_redirect();
      t_redirect_cancel();
      t_prg_banks();
      t_audio_flag();
      t_mirror();
      t_wram_protect();
      t_write_latency();
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule